// File: doc/BRIEF.md
# RTC Time Access Sequencer

This block drives a byte-level serial master to read or set the time in a real-time clock chip. The chip keeps every BCD digit in its own 4-bit register. For a read request the sequencer raises chip-enable and runs a busy handshake on the chip's control register. It then fetches each digit pair and presents the results as packed BCD second, minute, hour, day, month and year bytes, plus a 4-bit weekday digit. A set request writes the same fields from packed BCD inputs, units digit before tens digit.

After reset the block checks whether the chip's oscillator has stopped. If it has, the sequencer turns off the periodic interval output, rewrites the control register, waits for busy to clear and loads the date 2000-01-01 00:00:00 with weekday 0. Conversion between binary and BCD is left to the caller, and so is any bus access.

Each byte goes out on a start/acknowledge handshake. A command byte carries a register address in bits 3:0, bit 5 set to mark an address, and bit 6 set to request a read. A data byte has bit 4 set and the value in bits 3:0. A read byte returns its value in the low four bits.

Top module: `rtc_seq`

## Requirements
- R1: Reset holds `chip_en` low, `done`/`err` low and all time outputs at zero. After reset, `chip_en` stays low for at least the gap time (GAP_CYC = ceil(GAP_NS*1000/CLK_PERIOD_PS) cycles). The block then raises it and issues command 0x6E followed by one read byte. A clear bit 1 in the returned value ends the power-up check with a `done` pulse and `err` low.
- R2: If bit 1 (oscillator stopped) of that read is set, the block sends 0x27, 0x10, 0x2E and 0x17, then polls with 0x6E plus a read. Polling stops when bit 0 is clear or after RETRY_MAX polls. The block then runs a full set sequence with second=0, minute=0, hour=0, day=1, month=1, year=0 and weekday=0.
- R3: Every request starts with `chip_en` high and the byte sequence 0x2E, 0x14 (24-hour mode written to control register 0xE), 0x6E, read.
- R4: If bit 0 (busy) of the handshake read is set, `chip_en` drops for at least GAP_CYC cycles and the whole handshake repeats.
- R5: If RETRY_MAX handshakes in a row report busy, the request is aborted with no digit register access. `chip_en` goes low and `done` pulses with `err` high.
- R6: A read visits register addresses 0x0,0x1,0x2,0x3,0x4,0x5,0x8,0x9,0xA,0xB,0xC,0xD,0x6 in that order. For each address it sends command 0x60|addr and then one read byte.
- R7: Each packed output equals units | (tens << 4), where units comes from the even address and tens from the odd one. Sec, min, hour, day, month and year use the pairs 0x0/1, 0x2/3, 0x4/5, 0x8/9, 0xA/B and 0xC/D. `get_wday` is the digit at 0x6.
- R8: A set visits the same addresses in the same order. For each address it sends 0x20|addr and then 0x10|nibble, units nibble before tens nibble, and the values are taken from the inputs latched at the request.
- R9: At the end of every operation `chip_en` stays low for at least GAP_CYC cycles. Then `done` pulses for exactly one cycle while `chip_en` is low.
- R10: A request is taken only when the block is idle. Requests during an operation or the power-up check are dropped, not queued. If both requests arrive together, the read wins.
- R11: `sm_start` pulses once per byte, only while `chip_en` is high, and never while a previous byte still awaits `sm_ack`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_req | input | 1 | Read request pulse |
| wr_req | input | 1 | Set request pulse |
| set_sec | input | 8 | Packed BCD seconds to write |
| set_min | input | 8 | Packed BCD minutes to write |
| set_hour | input | 8 | Packed BCD hours to write |
| set_day | input | 8 | Packed BCD day of month to write |
| set_mon | input | 8 | Packed BCD month to write |
| set_year | input | 8 | Packed BCD year to write |
| set_wday | input | 4 | Weekday digit to write |
| get_sec | output | 8 | Packed BCD seconds read |
| get_min | output | 8 | Packed BCD minutes read |
| get_hour | output | 8 | Packed BCD hours read |
| get_day | output | 8 | Packed BCD day read |
| get_mon | output | 8 | Packed BCD month read |
| get_year | output | 8 | Packed BCD year read |
| get_wday | output | 4 | Weekday digit read |
| done | output | 1 | One-cycle end-of-operation pulse |
| err | output | 1 | Abort flag, valid with `done` |
| chip_en | output | 1 | Chip-enable to the clock chip |
| sm_start | output | 1 | Start one byte on the serial master |
| sm_rd | output | 1 | 1: receive a byte, 0: send `sm_tx` |
| sm_tx | output | 8 | Byte to send |
| sm_ack | input | 1 | Byte finished |
| sm_rx | input | 4 | Low four bits of the received byte |

## Verification
The bench builds the block with CLK_PERIOD_PS=5000 and GAP_NS=40, which gives an 8-cycle chip-enable gap. It sets RETRY_MAX=4, so the abort after repeated busy replies and a success on the last allowed attempt both occur within a few hundred cycles. The same short settings make the busy poll during power-up recovery and the gap-length limits at every chip-enable rise cheap to reach. The serial master and clock chip are modelled at byte level with a 3-cycle acknowledge latency.

// File: rtl/rtc_seq_pkg.sv
package rtc_seq_pkg;

   typedef enum logic [4:0] {
      ST_BOOT, ST_CHK_A, ST_CHK_D,
      ST_RCV_IA, ST_RCV_ID, ST_RCV_CA, ST_RCV_CD, ST_RCV_PA, ST_RCV_PD,
      ST_IDLE,
      ST_HS_CA, ST_HS_CD, ST_HS_RA, ST_HS_RD, ST_HS_GAP,
      ST_FLD_A, ST_FLD_D,
      ST_END
   } seq_st_t;

   // command byte flags
   localparam logic [7:0] CMD_ADDR = 8'h20;
   localparam logic [7:0] CMD_READ = 8'h40;
   localparam logic [7:0] CMD_DATA = 8'h10;

   localparam logic [3:0] REG_CTRL     = 4'hE;
   localparam logic [3:0] REG_INTV     = 4'h7;
   localparam logic [3:0] CTRL_RUN     = 4'h4;
   localparam logic [3:0] CTRL_RECOVER = 4'h7;
   localparam logic [3:0] INTV_OFF     = 4'h0;

   localparam int BUSY_BIT = 0;
   localparam int STOP_BIT = 1;

   localparam int          NSTEPS    = 13;
   localparam logic [3:0]  LAST_STEP = 4'(NSTEPS - 1);

   // step k: field k/2, digit k%2 (units first); last step is the weekday
   function automatic logic [3:0] step_reg(input logic [3:0] k);
      logic [3:0] pair;
      pair = {k[3:1], 1'b0};
      if (k == LAST_STEP)
         return 4'h6;
      else if (k < 4'd6)
         return pair | {3'b000, k[0]};
      else
         return (pair | {3'b000, k[0]}) + 4'd2;
   endfunction

   // recovery date 2000-01-01 00:00:00, weekday 0
   function automatic logic [3:0] recover_nib(input int k);
      return (k == 6 || k == 8) ? 4'h1 : 4'h0;
   endfunction

endpackage

// File: rtl/rtc_seq_gap.sv
module rtc_seq_gap #(
   parameter int GAP_CYC = 140
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic expired
);
   localparam int CW = $clog2(GAP_CYC + 1);

   logic [CW-1:0] cnt;

   assign expired = run && (cnt == CW'(GAP_CYC - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (!run)
         cnt <= '0;
      else if (!expired)
         cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/rtc_seq_step_map.sv
module rtc_seq_step_map
   import rtc_seq_pkg::*;
(
   input  logic [3:0] step,
   output logic [3:0] reg_addr,
   output logic       is_last
);
   assign reg_addr = step_reg(step);
   assign is_last  = (step == LAST_STEP);
endmodule

// File: rtl/rtc_seq_nibbles.sv
module rtc_seq_nibbles
   import rtc_seq_pkg::*;
(
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  load_user,
   input  logic [NSTEPS*4-1:0]   user_flat,
   input  logic                  load_dflt,
   input  logic                  cap_en,
   input  logic [3:0]            step,
   input  logic [3:0]            cap_val,
   output logic [3:0]            wr_nib,
   output logic [NSTEPS*4-1:0]   rd_flat
);
   logic [3:0] wr_q [NSTEPS];
   logic [3:0] rd_q [NSTEPS];

   for (genvar i = 0; i < NSTEPS; i++) begin : g_digit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            wr_q[i] <= '0;
            rd_q[i] <= '0;
         end else begin
            if (load_user)
               wr_q[i] <= user_flat[4*i +: 4];
            else if (load_dflt)
               wr_q[i] <= recover_nib(i);
            if (cap_en && step == 4'(i))
               rd_q[i] <= cap_val;
         end
      end
      assign rd_flat[4*i +: 4] = rd_q[i];
   end

   assign wr_nib = (step <= LAST_STEP) ? wr_q[step] : 4'h0;
endmodule

// File: rtl/rtc_seq.sv
module rtc_seq
   import rtc_seq_pkg::*;
#(
   parameter int CLK_PERIOD_PS = 5000,
   parameter int GAP_NS        = 700,
   parameter int RETRY_MAX     = 101
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       rd_req,
   input  logic       wr_req,
   input  logic [7:0] set_sec,
   input  logic [7:0] set_min,
   input  logic [7:0] set_hour,
   input  logic [7:0] set_day,
   input  logic [7:0] set_mon,
   input  logic [7:0] set_year,
   input  logic [3:0] set_wday,
   output logic [7:0] get_sec,
   output logic [7:0] get_min,
   output logic [7:0] get_hour,
   output logic [7:0] get_day,
   output logic [7:0] get_mon,
   output logic [7:0] get_year,
   output logic [3:0] get_wday,
   output logic       done,
   output logic       err,
   output logic       chip_en,
   output logic       sm_start,
   output logic       sm_rd,
   output logic [7:0] sm_tx,
   input  logic       sm_ack,
   input  logic [3:0] sm_rx
);
   localparam int GAP_CYC = (GAP_NS * 1000 + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;
   localparam int AW      = $clog2(RETRY_MAX + 1);
   localparam logic [AW-1:0] LAST_TRY = AW'(RETRY_MAX - 1);

   if (CLK_PERIOD_PS < 1 || GAP_NS < 1) begin : g_bad_timing
      $error("rtc_seq: clock period and gap must be positive");
   end
   if (RETRY_MAX < 1) begin : g_bad_retry
      $error("rtc_seq: RETRY_MAX must be at least 1");
   end

   seq_st_t        state;
   logic           pend;
   logic [AW-1:0]  att;
   logic [3:0]     step;
   logic           op_rd;
   logic           err_lat;
   logic           gap_run, gap_exp;
   logic           is_byte, adv;
   logic [3:0]     fld_addr, wr_nib;
   logic           fld_last;
   logic           load_user, load_dflt, cap_en, poll_end;
   logic [NSTEPS*4-1:0] rd_flat;

   assign gap_run = (state == ST_BOOT) || (state == ST_HS_GAP) || (state == ST_END);
   assign chip_en = !(gap_run || state == ST_IDLE);
   assign is_byte = chip_en;
   assign sm_start = is_byte && !pend;
   assign adv      = pend && sm_ack;

   assign poll_end  = !sm_rx[BUSY_BIT] || (att == LAST_TRY);
   assign load_user = (state == ST_IDLE) && !rd_req && wr_req;
   assign load_dflt = (state == ST_RCV_PD) && adv && poll_end;
   assign cap_en    = (state == ST_FLD_D) && adv && op_rd;

   rtc_seq_gap #(.GAP_CYC(GAP_CYC)) u_gap (
      .clk(clk), .rst_n(rst_n), .run(gap_run), .expired(gap_exp)
   );

   rtc_seq_step_map u_map (
      .step(step), .reg_addr(fld_addr), .is_last(fld_last)
   );

   rtc_seq_nibbles u_nib (
      .clk(clk), .rst_n(rst_n),
      .load_user(load_user),
      .user_flat({set_wday, set_year, set_mon, set_day, set_hour, set_min, set_sec}),
      .load_dflt(load_dflt),
      .cap_en(cap_en), .step(step), .cap_val(sm_rx),
      .wr_nib(wr_nib), .rd_flat(rd_flat)
   );

   assign {get_wday, get_year, get_mon, get_day, get_hour, get_min, get_sec} = rd_flat;

   always_comb begin
      sm_rd = 1'b0;
      sm_tx = 8'h00;
      case (state)
         ST_CHK_A, ST_RCV_PA, ST_HS_RA: sm_tx = CMD_READ | CMD_ADDR | {4'h0, REG_CTRL};
         ST_CHK_D, ST_RCV_PD, ST_HS_RD: sm_rd = 1'b1;
         ST_RCV_IA:                     sm_tx = CMD_ADDR | {4'h0, REG_INTV};
         ST_RCV_ID:                     sm_tx = CMD_DATA | {4'h0, INTV_OFF};
         ST_RCV_CA, ST_HS_CA:           sm_tx = CMD_ADDR | {4'h0, REG_CTRL};
         ST_RCV_CD:                     sm_tx = CMD_DATA | {4'h0, CTRL_RECOVER};
         ST_HS_CD:                      sm_tx = CMD_DATA | {4'h0, CTRL_RUN};
         ST_FLD_A: sm_tx = (op_rd ? (CMD_READ | CMD_ADDR) : CMD_ADDR) | {4'h0, fld_addr};
         ST_FLD_D: begin
            sm_rd = op_rd;
            sm_tx = op_rd ? 8'h00 : (CMD_DATA | {4'h0, wr_nib});
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_BOOT;
         pend    <= 1'b0;
         att     <= '0;
         step    <= '0;
         op_rd   <= 1'b0;
         err_lat <= 1'b0;
         done    <= 1'b0;
         err     <= 1'b0;
      end else begin
         done <= 1'b0;
         err  <= 1'b0;
         if (sm_start)
            pend <= 1'b1;
         else if (sm_ack)
            pend <= 1'b0;

         case (state)
            ST_BOOT:   if (gap_exp) state <= ST_CHK_A;
            ST_CHK_A:  if (adv) state <= ST_CHK_D;
            ST_CHK_D:  if (adv) state <= sm_rx[STOP_BIT] ? ST_RCV_IA : ST_END;
            ST_RCV_IA: if (adv) state <= ST_RCV_ID;
            ST_RCV_ID: if (adv) state <= ST_RCV_CA;
            ST_RCV_CA: if (adv) state <= ST_RCV_CD;
            ST_RCV_CD: if (adv) begin
               att   <= '0;
               state <= ST_RCV_PA;
            end
            ST_RCV_PA: if (adv) state <= ST_RCV_PD;
            ST_RCV_PD: if (adv) begin
               if (poll_end) begin
                  att   <= '0;
                  op_rd <= 1'b0;
                  state <= ST_HS_CA;
               end else begin
                  att   <= att + 1'b1;
                  state <= ST_RCV_PA;
               end
            end
            ST_IDLE: begin
               if (rd_req || wr_req) begin
                  op_rd   <= rd_req;
                  att     <= '0;
                  err_lat <= 1'b0;
                  state   <= ST_HS_CA;
               end
            end
            ST_HS_CA:  if (adv) state <= ST_HS_CD;
            ST_HS_CD:  if (adv) state <= ST_HS_RA;
            ST_HS_RA:  if (adv) state <= ST_HS_RD;
            ST_HS_RD: if (adv) begin
               if (sm_rx[BUSY_BIT]) begin
                  if (att == LAST_TRY) begin
                     err_lat <= 1'b1;
                     state   <= ST_END;
                  end else begin
                     att   <= att + 1'b1;
                     state <= ST_HS_GAP;
                  end
               end else begin
                  step  <= '0;
                  state <= ST_FLD_A;
               end
            end
            ST_HS_GAP: if (gap_exp) state <= ST_HS_CA;
            ST_FLD_A:  if (adv) state <= ST_FLD_D;
            ST_FLD_D: if (adv) begin
               if (fld_last)
                  state <= ST_END;
               else begin
                  step  <= step + 1'b1;
                  state <= ST_FLD_A;
               end
            end
            ST_END: if (gap_exp) begin
               done  <= 1'b1;
               err   <= err_lat;
               state <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/rtc_seq_chk.sv
module rtc_seq_chk #(
   parameter int GAP_CYC = 140
) (
   input logic clk,
   input logic rst_n,
   input logic chip_en,
   input logic sm_start,
   input logic sm_ack,
   input logic done,
   input logic err
);
   localparam int CW = $clog2(GAP_CYC + 2);

   logic [CW-1:0] low_run;
   logic          outstanding;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         low_run     <= '0;
         outstanding <= 1'b0;
      end else begin
         if (chip_en)
            low_run <= '0;
         else if (low_run < CW'(GAP_CYC))
            low_run <= low_run + 1'b1;
         if (sm_start)
            outstanding <= 1'b1;
         else if (sm_ack)
            outstanding <= 1'b0;
      end
   end

   // R4 / R9: every chip-enable rise follows a full low gap
   assert_ce_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(chip_en) |-> (low_run >= CW'(GAP_CYC)));

   assert_done_ce_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !chip_en);

   assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_err_with_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> done);

   assert_start_under_ce_R11: assert property (@(posedge clk) disable iff (!rst_n)
      sm_start |-> chip_en);

   assert_no_overlap_R11: assert property (@(posedge clk) disable iff (!rst_n)
      sm_start |-> !outstanding);
endmodule

bind rtc_seq rtc_seq_chk #(.GAP_CYC(GAP_CYC)) u_chk (
   .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .sm_start(sm_start),
   .sm_ack(sm_ack), .done(done), .err(err)
);

// File: tb/rtc_seq_test.sv
module rtc_seq_test;
   localparam int B_GAP   = 8;
   localparam int B_RETRY = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic rd_req = 1'b0, wr_req = 1'b0;
   logic [7:0] set_sec = 0, set_min = 0, set_hour = 0, set_day = 0, set_mon = 0, set_year = 0;
   logic [3:0] set_wday = 0;
   logic [7:0] get_sec, get_min, get_hour, get_day, get_mon, get_year;
   logic [3:0] get_wday;
   logic done, err, chip_en, sm_start, sm_rd, sm_ack;
   logic [7:0] sm_tx;
   logic [3:0] sm_rx;

   always #2.5 clk = ~clk;

   rtc_seq #(.CLK_PERIOD_PS(5000), .GAP_NS(40), .RETRY_MAX(B_RETRY)) uut (
      .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .wr_req(wr_req),
      .set_sec(set_sec), .set_min(set_min), .set_hour(set_hour), .set_day(set_day),
      .set_mon(set_mon), .set_year(set_year), .set_wday(set_wday),
      .get_sec(get_sec), .get_min(get_min), .get_hour(get_hour), .get_day(get_day),
      .get_mon(get_mon), .get_year(get_year), .get_wday(get_wday),
      .done(done), .err(err), .chip_en(chip_en), .sm_start(sm_start), .sm_rd(sm_rd),
      .sm_tx(sm_tx), .sm_ack(sm_ack), .sm_rx(sm_rx)
   );

   int checks = 0, fails = 0, cyc = 0;

   // ---------------- chip and serial master model ----------------
   logic [3:0] mreg [0:15];
   logic       stop_flag = 1'b0;
   int         busy_left = 0;
   int         ctrl4 = 0;
   logic       have_addr = 1'b0, cur_read = 1'b0;
   logic [3:0] cur_addr = 4'h0;
   int         ack_cnt = 0;
   logic [8:0] log_q [0:511];
   int         log_n = 0;
   int         ce_bad = 0, ovl_bad = 0, gap_bad = 0, low_run = 0;
   logic [3:0] v;

   initial begin
      sm_ack = 1'b0;
      sm_rx  = 4'h0;
      for (int i = 0; i < 16; i++) mreg[i] = 4'h0;
   end

   always @(negedge clk) begin
      if (!rst_n) begin
         sm_ack = 1'b0;
         ack_cnt = 0;
         have_addr = 1'b0;
      end else begin
         if (sm_ack) sm_ack = 1'b0;
         if (ack_cnt > 0) begin
            if (sm_start) ovl_bad++;
            ack_cnt--;
            if (ack_cnt == 0) sm_ack = 1'b1;
         end else if (sm_start) begin
            if (!chip_en) ce_bad++;
            if (log_n < 512) begin
               log_q[log_n] = sm_rd ? 9'h100 : {1'b0, sm_tx};
               log_n++;
            end
            if (sm_rd) begin
               v = 4'hF;
               if (have_addr && cur_read) begin
                  if (cur_addr == 4'hE) begin
                     v = {2'b01, stop_flag, busy_left > 0};
                     if (busy_left > 0) busy_left--;
                  end else
                     v = mreg[cur_addr];
               end
               sm_rx = v;
               have_addr = 1'b0;
            end else if (sm_tx[5]) begin
               have_addr = 1'b1;
               cur_addr  = sm_tx[3:0];
               cur_read  = sm_tx[6];
            end else if (sm_tx[4] && have_addr && !cur_read) begin
               mreg[cur_addr] = sm_tx[3:0];
               if (cur_addr == 4'hE) begin
                  stop_flag = 1'b0;
                  if (sm_tx[3:0] == 4'h4) ctrl4++;
               end
               have_addr = 1'b0;
            end
            ack_cnt = 2;
         end
      end
      // chip-enable low time before each rise
      if (chip_en) begin
         if (low_run > 0 && low_run < B_GAP) gap_bad++;
         low_run = 0;
      end else
         low_run++;
   end

   // ---------------- checking helpers ----------------
   logic [8:0] exp_q [0:511];
   int         exp_n = 0;
   logic [3:0] want [0:15];
   logic       got_err;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
      end
   endtask

   function automatic logic [3:0] addr_of(input int k);
      case (k)
         0: return 4'h0;  1: return 4'h1;  2: return 4'h2;  3: return 4'h3;
         4: return 4'h4;  5: return 4'h5;  6: return 4'h8;  7: return 4'h9;
         8: return 4'hA;  9: return 4'hB;  10: return 4'hC; 11: return 4'hD;
         default: return 4'h6;
      endcase
   endfunction

   task automatic push(input bit rd, input logic [7:0] b);
      exp_q[exp_n] = rd ? 9'h100 : {1'b0, b};
      exp_n++;
   endtask

   task automatic exp_hs();
      push(0, 8'h2E); push(0, 8'h14); push(0, 8'h6E); push(1, 8'h00);
   endtask

   // nibble values of a set come from want[] indexed by address
   task automatic exp_fields(input bit rd);
      for (int k = 0; k < 13; k++) begin
         if (rd) begin
            push(0, 8'h60 | {4'h0, addr_of(k)}); push(1, 8'h00);
         end else begin
            push(0, 8'h20 | {4'h0, addr_of(k)}); push(0, 8'h10 | {4'h0, want[addr_of(k)]});
         end
      end
   endtask

   task automatic cmp_log(input string req);
      int bad;
      bad = -1;
      for (int i = 0; i < exp_n && i < log_n; i++)
         if (bad < 0 && log_q[i] != exp_q[i]) bad = i;
      if (log_n != exp_n)
         chk(0, req, "byte count", log_n, exp_n);
      else if (bad >= 0)
         chk(0, req, $sformatf("byte %0d", bad), log_q[bad], exp_q[bad]);
      else
         chk(1, req, "byte log", 0, 0);
   endtask

   task automatic clear_logs();
      log_n = 0; exp_n = 0; ctrl4 = 0;
   endtask

   task automatic wait_done(input string req);
      bit seen;
      seen = 0;
      for (int i = 0; i < 5000 && !seen; i++) begin
         @(negedge clk);
         if (done) begin seen = 1; got_err = err; end
      end
      if (!seen) chk(0, req, "done timeout", 0, 1);
   endtask

   task automatic pulse(input bit rd, input bit wr);
      @(negedge clk);
      rd_req = rd; wr_req = wr;
      @(negedge clk);
      rd_req = 0; wr_req = 0;
   endtask

   task automatic set_inputs(input logic [7:0] s, mi, h, d, mo, y, input logic [3:0] w);
      set_sec = s; set_min = mi; set_hour = h; set_day = d; set_mon = mo; set_year = y;
      set_wday = w;
   endtask

   task automatic want_from(input logic [7:0] s, mi, h, d, mo, y, input logic [3:0] w);
      for (int i = 0; i < 16; i++) want[i] = mreg[i];
      want[0] = s[3:0];  want[1] = s[7:4];  want[2] = mi[3:0]; want[3] = mi[7:4];
      want[4] = h[3:0];  want[5] = h[7:4];  want[8] = d[3:0];  want[9] = d[7:4];
      want[10] = mo[3:0]; want[11] = mo[7:4]; want[12] = y[3:0]; want[13] = y[7:4];
      want[6] = w;
   endtask

   task automatic cmp_image(input string req);
      int bad;
      bad = -1;
      for (int i = 0; i < 16; i++) if (bad < 0 && mreg[i] != want[i]) bad = i;
      if (bad >= 0) chk(0, req, $sformatf("chip reg %0h", bad), mreg[bad], want[bad]);
      else chk(1, req, "chip image", 0, 0);
   endtask

   task automatic cmp_outputs(input string req, input logic [51:0] expv);
      logic [51:0] act;
      act = {get_wday, get_year, get_mon, get_day, get_hour, get_min, get_sec};
      chk(act == expv, req, "packed outputs", act, expv);
   endtask

   task automatic do_reset(input bit stop);
      rst_n = 0;
      stop_flag = stop;
      busy_left = 0;
      clear_logs();
      repeat (4) @(negedge clk);
      chk(!chip_en && !done && !err, "R1", "reset ce/done/err", {chip_en, done, err}, 0);
      rst_n = 1;
   endtask

   // ---------------- scenarios ----------------
   task automatic t_boot_clean();
      for (int i = 0; i < 16; i++) mreg[i] = 4'h3;
      do_reset(0);
      cmp_outputs("R1", 52'h0);
      wait_done("R1");
      chk(got_err == 0, "R1", "err after clean boot", got_err, 0);
      push(0, 8'h6E); push(1, 8'h00);
      cmp_log("R1");
      chk(gap_bad == 0, "R1", "ce low before first rise", gap_bad, 0);
   endtask

   task automatic t_boot_recover();
      for (int i = 0; i < 16; i++) mreg[i] = 4'h9;
      do_reset(1);
      wait_done("R2");
      chk(got_err == 0, "R2", "err after recovery", got_err, 0);
      for (int i = 0; i < 16; i++) want[i] = mreg[i];
      want_from(8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h00, 4'h0);
      want[7] = 4'h0;
      want[14] = 4'h4;
      push(0, 8'h6E); push(1, 8'h00);
      push(0, 8'h27); push(0, 8'h10); push(0, 8'h2E); push(0, 8'h17);
      push(0, 8'h6E); push(1, 8'h00);
      exp_hs();
      exp_fields(0);
      cmp_log("R2");
      cmp_image("R2");
   endtask

   task automatic t_read();
      mreg[0] = 4'h8; mreg[1] = 4'h5; mreg[2] = 4'h9; mreg[3] = 4'h5;
      mreg[4] = 4'h3; mreg[5] = 4'h2; mreg[8] = 4'h1; mreg[9] = 4'h3;
      mreg[10] = 4'h2; mreg[11] = 4'h1; mreg[12] = 4'h1; mreg[13] = 4'h3;
      mreg[6] = 4'h5;
      clear_logs();
      pulse(1, 0);
      wait_done("R6");
      chk(got_err == 0, "R3", "err on read", got_err, 0);
      exp_hs();
      exp_fields(1);
      cmp_log("R6");
      chk(ctrl4 == 1, "R3", "24h control writes", ctrl4, 1);
      cmp_outputs("R7", {4'h5, 8'h31, 8'h12, 8'h31, 8'h23, 8'h59, 8'h58});
   endtask

   task automatic t_set();
      set_inputs(8'h07, 8'h45, 8'h19, 8'h28, 8'h02, 8'h24, 4'h3);
      want_from(8'h07, 8'h45, 8'h19, 8'h28, 8'h02, 8'h24, 4'h3);
      want[14] = 4'h4;
      clear_logs();
      pulse(0, 1);
      set_inputs(8'h99, 8'h99, 8'h99, 8'h99, 8'h99, 8'h99, 4'h9);
      wait_done("R8");
      chk(got_err == 0, "R8", "err on set", got_err, 0);
      exp_hs();
      exp_fields(0);
      cmp_log("R8");
      cmp_image("R8");
   endtask

   task automatic t_retry();
      busy_left = 3;
      clear_logs();
      pulse(1, 0);
      wait_done("R4");
      chk(got_err == 0, "R4", "err after retries", got_err, 0);
      for (int i = 0; i < 4; i++) exp_hs();
      exp_fields(1);
      cmp_log("R4");
      chk(ctrl4 == 4, "R4", "handshake count", ctrl4, 4);
      chk(gap_bad == 0, "R4", "ce low gaps", gap_bad, 0);
      cmp_outputs("R4", {4'h3, 8'h24, 8'h02, 8'h28, 8'h19, 8'h45, 8'h07});
   endtask

   task automatic t_timeout();
      busy_left = 50;
      clear_logs();
      pulse(1, 0);
      wait_done("R5");
      chk(got_err == 1, "R5", "err on timeout", got_err, 1);
      chk(chip_en == 0, "R5", "ce after abort", chip_en, 0);
      for (int i = 0; i < B_RETRY; i++) exp_hs();
      cmp_log("R5");
      cmp_outputs("R5", {4'h3, 8'h24, 8'h02, 8'h28, 8'h19, 8'h45, 8'h07});
      busy_left = 0;
   endtask

   task automatic t_ignore();
      int n_after;
      bit extra;
      for (int i = 0; i < 16; i++) want[i] = mreg[i];
      set_inputs(8'h11, 8'h11, 8'h11, 8'h11, 8'h11, 8'h11, 4'h1);
      clear_logs();
      pulse(1, 1);
      wait_done("R10");
      exp_hs();
      exp_fields(1);
      cmp_log("R10");
      cmp_image("R10");
      clear_logs();
      pulse(1, 0);
      repeat (6) @(negedge clk);
      pulse(0, 1);
      wait_done("R10");
      n_after = log_n;
      extra = 0;
      for (int i = 0; i < 300; i++) begin
         @(negedge clk);
         if (done || chip_en) extra = 1;
      end
      chk(!extra && log_n == n_after, "R10", "activity after dropped request",
          log_n, n_after);
      cmp_image("R10");
      chk(ce_bad == 0 && ovl_bad == 0, "R11", "start rule violations",
          ce_bad + ovl_bad, 0);
      chk(gap_bad == 0, "R9", "ce low gaps", gap_bad, 0);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         fails++;
         checks++;
         $display("FAIL watchdog: actual %0d expected < 150000 cycles", cyc);
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

   initial begin
      t_boot_clean();
      t_boot_recover();
      t_read();
      t_set();
      t_retry();
      t_timeout();
      t_ignore();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule